// File: doc/BRIEF.md
# Redirection Table Register Window

This block is the software-visible register front end of an I/O interrupt controller with a parameterised number of input pins (24 by default). Software sees two 32-bit locations on a simple read/write port: a select register and a data window. The value in the select register decides what the window reaches. It can reach an identification register, a read-only version word, an arbitration word that mirrors the identification value, or one half of a 64-bit routing entry. There is one routing entry for each pin.

The block holds the routing table in flip-flops and presents every field of every entry to the pin-servicing logic in parallel. The pin logic sets an entry's remote-IRR status bit through a dedicated strobe input. Software can clear that bit, but only by writing the entry's low half; the window never sets it. Whenever a low-half write changes an entry's mask bit, the block raises a one-cycle notification that carries the pin index and the new mask value.

Top module: `irq_redir_window`

## Requirements
- R1: After synchronous reset, the select register reads 0, the identification value reads 0, every entry reads 0x0001_0000 in its low half (mask set, all else clear), rvalid is low and no mask-change strobe is raised.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: A read request is answered in the next cycle: bus_rvalid is high exactly in the cycle after bus_rd, and bus_rdata then holds the addressed value.
- R4: With select 0x01, the window reads (NPIN-1) in bits 23:16 and VERSION in bits 7:0, with other bits zero. Writes there are ignored.
- R5: With select 0x00, the window reads and writes a 4-bit identification value in bits 27:24. With select 0x02, it reads that same value, and writes there are ignored.
- R6: For select s ≥ 0x10, the entry index is (s−0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32. Selects 0x03–0x0F read 0 and ignore writes.
- R7: A window access whose entry index is NPIN or more reads 0 and leaves the whole table unchanged.
- R8: A low-half write forces the entry's remote-IRR bit (bit 14) to 0 regardless of the written bit 14. A high-half write leaves it unchanged.
- R9: The remote-IRR bit is set only by a pulse on rirr_set[p]. A set in the same cycle as a low-half write to that entry leaves the bit at 1.
- R10: When a low-half write changes an entry's mask bit (bit 16), mchg_valid is high for one cycle after the write, with mchg_idx equal to the entry index and mchg_mask equal to the new mask. A write that leaves the mask unchanged raises nothing.
- R11: The field outputs follow the entry layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| rirr_set | input | NPIN | Per-pin remote-IRR set pulse from pin logic |
| ent_vector | output | NPIN*8 | Vector field of each entry |
| ent_dlv | output | NPIN*3 | Delivery mode of each entry |
| ent_dst_mode | output | NPIN | Destination mode of each entry |
| ent_pol | output | NPIN | Polarity of each entry |
| ent_level | output | NPIN | Trigger mode (1 = level) of each entry |
| ent_rirr | output | NPIN | Remote-IRR status of each entry |
| ent_mask | output | NPIN | Mask bit of each entry |
| ent_dest | output | NPIN*8 | Destination field of each entry |
| mchg_valid | output | 1 | Mask-change strobe |
| mchg_idx | output | IDX_W | Entry index of the mask change |
| mchg_mask | output | 1 | New mask value |

## Verification
The hardest situation to reach is the interplay of the remote-IRR bit with software writes. The bit can only be raised from the pin side, so the stimulus pulses rirr_set for a chosen pin. It then writes the high half and checks that the bit survives. Next it writes the low half with bit 14 set in the data and checks that the bit is still forced to zero. A further case issues a set pulse in the same cycle as a low-half write. The last-pin and first-out-of-range selects, and upper address bits that alias onto the decoded offsets, are driven explicitly. A behavioural model checks the table fields, the read data and the mask strobe every cycle.

// File: rtl/irw_pkg.sv
package irw_pkg;
  // window targets reached through the select register
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_IDENT  = 3'd1,
    TGT_VER    = 3'd2,
    TGT_ARB    = 3'd3,
    TGT_ENT_LO = 3'd4,
    TGT_ENT_HI = 3'd5
  } win_tgt_e;

  // entry field positions
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DSTM_BIT  = 11;
  localparam int POL_BIT   = 13;
  localparam int RIRR_BIT  = 14;
  localparam int LEVEL_BIT = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  localparam logic [63:0] ENT_RST = 64'h1 << MASK_BIT;

  // select values of the fixed registers
  localparam logic [31:0] SEL_IDENT = 32'h0;
  localparam logic [31:0] SEL_VER   = 32'h1;
  localparam logic [31:0] SEL_ARB   = 32'h2;
  localparam logic [31:0] SEL_ENT0  = 32'h10;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int NPIN  = 24,
  parameter int IDX_W = 5
) (
  input  logic [31:0]      sel,
  output win_tgt_e         tgt,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] off;

  always_comb begin
    off = sel - SEL_ENT0;
    tgt = TGT_NONE;
    idx = off[IDX_W:1];
    if (sel == SEL_IDENT)      tgt = TGT_IDENT;
    else if (sel == SEL_VER)   tgt = TGT_VER;
    else if (sel == SEL_ARB)   tgt = TGT_ARB;
    else if (sel >= SEL_ENT0 && (off >> 1) < NPIN)
      tgt = sel[0] ? TGT_ENT_HI : TGT_ENT_LO;
  end
endmodule

// File: rtl/irw_entry_table.sv
module irw_entry_table
  import irw_pkg::*;
#(
  parameter int NPIN  = 24,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wdata,
  input  logic [NPIN-1:0]        rirr_set,
  output logic [NPIN-1:0][63:0]  tbl,
  output logic                   mchg_valid,
  output logic [IDX_W-1:0]       mchg_idx,
  output logic                   mchg_mask
);
  logic [NPIN-1:0] mask_vec;

  for (genvar p = 0; p < NPIN; p++) begin : g_ent
    logic [63:0] ent_q, ent_d;
    logic        hit;

    assign hit = (wr_idx == IDX_W'(p));

    always_comb begin
      ent_d = ent_q;
      if (wr_lo && hit) begin
        ent_d[31:0]     = wdata;
        ent_d[RIRR_BIT] = 1'b0;
      end
      if (wr_hi && hit) ent_d[63:32] = wdata;
      if (rirr_set[p])  ent_d[RIRR_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) ent_q <= ENT_RST;
      else     ent_q <= ent_d;
    end

    assign tbl[p]      = ent_q;
    assign mask_vec[p] = ent_q[MASK_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mchg_valid <= 1'b0;
      mchg_idx   <= '0;
      mchg_mask  <= 1'b0;
    end else begin
      mchg_valid <= wr_lo && (wdata[MASK_BIT] != mask_vec[wr_idx]);
      if (wr_lo) begin
        mchg_idx  <= wr_idx;
        mchg_mask <= wdata[MASK_BIT];
      end
    end
  end
endmodule

// File: rtl/irw_read_port.sv
module irw_read_port
  import irw_pkg::*;
#(
  parameter int          NPIN    = 24,
  parameter int          IDX_W   = 5,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic                  hit_sel,
  input  logic                  hit_win,
  input  logic [31:0]           sel,
  input  win_tgt_e              tgt,
  input  logic [IDX_W-1:0]      idx,
  input  logic [3:0]            ident,
  input  logic [NPIN-1:0][63:0] tbl,
  output logic [31:0]           rdata,
  output logic                  rvalid
);
  localparam logic [7:0] MAXPIN = 8'(NPIN - 1);

  logic [31:0] win_val, rd_val;

  always_comb begin
    case (tgt)
      TGT_IDENT, TGT_ARB: win_val = {4'h0, ident, 24'h0};
      TGT_VER:            win_val = {8'h0, MAXPIN, 8'h0, VERSION};
      TGT_ENT_LO:         win_val = tbl[idx][31:0];
      TGT_ENT_HI:         win_val = tbl[idx][63:32];
      default:            win_val = 32'h0;
    endcase
    if (hit_sel)      rd_val = sel;
    else if (hit_win) rd_val = win_val;
    else              rd_val = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= 32'h0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_val;
    end
  end
endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window
  import irw_pkg::*;
#(
  parameter int         NPIN    = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h11,
  parameter logic [7:0] OFS_SEL = 8'h00,
  parameter logic [7:0] OFS_WIN = 8'h10,
  localparam int        IDX_W   = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NPIN-1:0]     rirr_set,
  output logic [NPIN*8-1:0]   ent_vector,
  output logic [NPIN*3-1:0]   ent_dlv,
  output logic [NPIN-1:0]     ent_dst_mode,
  output logic [NPIN-1:0]     ent_pol,
  output logic [NPIN-1:0]     ent_level,
  output logic [NPIN-1:0]     ent_rirr,
  output logic [NPIN-1:0]     ent_mask,
  output logic [NPIN*8-1:0]   ent_dest,
  output logic                mchg_valid,
  output logic [IDX_W-1:0]    mchg_idx,
  output logic                mchg_mask
);
  logic [7:0]  ofs;
  logic        hit_sel, hit_win;
  logic [31:0] sel_q;
  logic [3:0]  ident_q;
  win_tgt_e    tgt;
  logic [IDX_W-1:0] wr_idx;
  logic        wr_lo, wr_hi;
  logic [NPIN-1:0][63:0] tbl;
  logic        unused_addr_hi;

  assign ofs            = bus_addr[7:0];
  assign unused_addr_hi = ^bus_addr;
  assign hit_sel        = (ofs == OFS_SEL);
  assign hit_win        = (ofs == OFS_WIN);

  irw_decode #(.NPIN(NPIN), .IDX_W(IDX_W)) i_decode (
    .sel (sel_q),
    .tgt (tgt),
    .idx (wr_idx)
  );

  assign wr_lo = bus_wr && hit_win && (tgt == TGT_ENT_LO);
  assign wr_hi = bus_wr && hit_win && (tgt == TGT_ENT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 32'h0;
      ident_q <= 4'h0;
    end else begin
      if (bus_wr && hit_sel) sel_q <= bus_wdata;
      if (bus_wr && hit_win && tgt == TGT_IDENT) ident_q <= bus_wdata[27:24];
    end
  end

  irw_entry_table #(.NPIN(NPIN), .IDX_W(IDX_W)) i_table (
    .clk        (clk),
    .rst        (rst),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wr_idx     (wr_idx),
    .wdata      (bus_wdata),
    .rirr_set   (rirr_set),
    .tbl        (tbl),
    .mchg_valid (mchg_valid),
    .mchg_idx   (mchg_idx),
    .mchg_mask  (mchg_mask)
  );

  irw_read_port #(.NPIN(NPIN), .IDX_W(IDX_W), .VERSION(VERSION)) i_rdport (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .sel     (sel_q),
    .tgt     (tgt),
    .idx     (wr_idx),
    .ident   (ident_q),
    .tbl     (tbl),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_fld
    assign ent_vector[p*8 +: 8] = tbl[p][VEC_LSB +: 8];
    assign ent_dlv[p*3 +: 3]    = tbl[p][DLV_LSB +: 3];
    assign ent_dst_mode[p]      = tbl[p][DSTM_BIT];
    assign ent_pol[p]           = tbl[p][POL_BIT];
    assign ent_rirr[p]          = tbl[p][RIRR_BIT];
    assign ent_level[p]         = tbl[p][LEVEL_BIT];
    assign ent_mask[p]          = tbl[p][MASK_BIT];
    assign ent_dest[p*8 +: 8]   = tbl[p][DEST_LSB +: 8];
  end
endmodule

// File: rtl/irq_redir_window_chk.sv
module irq_redir_window_chk #(
  parameter int NPIN  = 24,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_rvalid,
  input logic [NPIN-1:0]  rirr_set,
  input logic [NPIN-1:0]  ent_rirr,
  input logic [NPIN-1:0]  ent_mask,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic [IDX_W-1:0] wr_idx,
  input logic             mchg_valid,
  input logic [IDX_W-1:0] mchg_idx,
  input logic             mchg_mask
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (&ent_mask && !mchg_valid && !bus_rvalid));

  // R3
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R3
  rvalid_only_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  // R10
  mchg_matches_table_chk: assert property (@(posedge clk) disable iff (rst)
    mchg_valid |-> (ent_mask[mchg_idx] == mchg_mask));

  // R10
  mchg_needs_low_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_lo |=> !mchg_valid);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    // R9
    rirr_rise_from_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ent_rirr[p]) |-> $past(rirr_set[p]));

    // R8
    rirr_low_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_lo && wr_idx == IDX_W'(p) && !rirr_set[p]) |=> !ent_rirr[p]);

    // R8
    rirr_high_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && wr_idx == IDX_W'(p) && !rirr_set[p]) |=> $stable(ent_rirr[p]));
  end
endmodule

bind irq_redir_window irq_redir_window_chk #(.NPIN(NPIN), .IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .rirr_set   (rirr_set),
  .ent_rirr   (ent_rirr),
  .ent_mask   (ent_mask),
  .wr_lo      (wr_lo),
  .wr_hi      (wr_hi),
  .wr_idx     (wr_idx),
  .mchg_valid (mchg_valid),
  .mchg_idx   (mchg_idx),
  .mchg_mask  (mchg_mask)
);

// File: tb/test_irq_redir_window.sv
module test_irq_redir_window;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 24;
  localparam int IDX_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [11:0]       bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [NPIN-1:0]   rirr_set = '0;
  logic [NPIN*8-1:0] ent_vector, ent_dest;
  logic [NPIN*3-1:0] ent_dlv;
  logic [NPIN-1:0]   ent_dst_mode, ent_pol, ent_level, ent_rirr, ent_mask;
  logic              mchg_valid, mchg_mask;
  logic [IDX_W-1:0]  mchg_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redir_window i_irq_redir_window (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rirr_set(rirr_set), .ent_vector(ent_vector), .ent_dlv(ent_dlv),
    .ent_dst_mode(ent_dst_mode), .ent_pol(ent_pol), .ent_level(ent_level),
    .ent_rirr(ent_rirr), .ent_mask(ent_mask), .ent_dest(ent_dest),
    .mchg_valid(mchg_valid), .mchg_idx(mchg_idx), .mchg_mask(mchg_mask)
  );

  int checks = 0, failures = 0;
  bit done = 0, cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_tbl [NPIN];
  logic [31:0] m_sel, m_rdata;
  logic [3:0]  m_id;
  bit          m_rvalid, m_strb, m_smask;
  int          m_sidx;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int ix;
    if (a[7:0] == 8'h00) return m_sel;
    if (a[7:0] != 8'h10) return 32'h0;
    if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
    if (m_sel == 1) return (32'(NPIN - 1) << 16) | 32'h11;
    if (m_sel < 16) return 32'h0;
    ix = int'((m_sel - 16) >> 1);
    if (ix >= NPIN) return 32'h0;
    return m_sel[0] ? m_tbl[ix][63:32] : m_tbl[ix][31:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_id = 0; m_rvalid = 0; m_strb = 0; m_rdata = 0;
      for (int p = 0; p < NPIN; p++) m_tbl[p] = 64'h1_0000;
    end else begin
      int ix;
      m_strb = 0;
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (bus_wr) begin
        if (bus_addr[7:0] == 8'h00) m_sel = bus_wdata;
        else if (bus_addr[7:0] == 8'h10) begin
          if (m_sel == 0) m_id = bus_wdata[27:24];
          else if (m_sel >= 16) begin
            ix = int'((m_sel - 16) >> 1);
            if (ix < NPIN) begin
              if (m_sel[0]) m_tbl[ix][63:32] = bus_wdata;
              else begin
                if (m_tbl[ix][16] != bus_wdata[16]) begin
                  m_strb = 1; m_sidx = ix; m_smask = bus_wdata[16];
                end
                m_tbl[ix][31:0] = bus_wdata & ~32'h4000;
              end
            end
          end
        end
      end
      for (int p = 0; p < NPIN; p++) if (rirr_set[p]) m_tbl[p][14] = 1'b1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit fok;
      chk(bus_rvalid == m_rvalid, "R3 rvalid", 64'(bus_rvalid), 64'(m_rvalid));
      if (m_rvalid) chk(bus_rdata == m_rdata, "R3 rdata", 64'(bus_rdata), 64'(m_rdata));
      chk(mchg_valid == m_strb, "R10 strobe", 64'(mchg_valid), 64'(m_strb));
      if (m_strb)
        chk(mchg_idx == IDX_W'(m_sidx) && mchg_mask == m_smask, "R10 idx/mask",
            {mchg_idx, mchg_mask}, {IDX_W'(m_sidx), m_smask});
      fok = 1;
      for (int p = 0; p < NPIN; p++) begin
        if (ent_vector[p*8 +: 8] != m_tbl[p][7:0] || ent_dlv[p*3 +: 3] != m_tbl[p][10:8] ||
            ent_dst_mode[p] != m_tbl[p][11] || ent_pol[p] != m_tbl[p][13] ||
            ent_rirr[p] != m_tbl[p][14] || ent_level[p] != m_tbl[p][15] ||
            ent_mask[p] != m_tbl[p][16] || ent_dest[p*8 +: 8] != m_tbl[p][63:56])
          fok = 0;
      end
      chk(fok, "R11 fields", 64'(ent_mask), 64'(fok));
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rvalid && bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk(&ent_mask && !mchg_valid && !bus_rvalid, "R1 reset outputs", 64'(ent_mask), 64'hFF_FFFF);
    rd_chk(12'h000, 32'h0, "R1 select after reset");
    rd_chk(12'h010, 32'h0, "R1 ident after reset");
    bus_write(12'h000, 32'h10);
    rd_chk(12'h010, 32'h0001_0000, "R1 entry0 low after reset");
    // R4 version
    bus_write(12'h000, 32'h1);
    rd_chk(12'h010, 32'h0017_0011, "R4 version");
    bus_write(12'h010, 32'hFFFF_FFFF);
    rd_chk(12'h010, 32'h0017_0011, "R4 version write ignored");
    // R5 ident / arbitration
    bus_write(12'h000, 32'h0);
    bus_write(12'h010, 32'hA500_0000);
    rd_chk(12'h010, 32'h0500_0000, "R5 ident");
    bus_write(12'h000, 32'h2);
    rd_chk(12'h010, 32'h0500_0000, "R5 arb mirrors ident");
    bus_write(12'h010, 32'h0F00_0000);
    rd_chk(12'h010, 32'h0500_0000, "R5 arb write ignored");
    // R6 unused low selects
    bus_write(12'h000, 32'h3);
    rd_chk(12'h010, 32'h0, "R6 select 0x03");
    bus_write(12'h000, 32'hF);
    bus_write(12'h010, 32'h1234_5678);
    rd_chk(12'h010, 32'h0, "R6 select 0x0F");
    // R6/R10/R11 pin 5 programming
    bus_write(12'h000, 32'h1A);
    bus_write(12'h010, 32'h0000_E542);
    chk(mchg_valid && mchg_idx == 5 && !mchg_mask, "R10 unmask strobe", {mchg_valid, mchg_idx, mchg_mask}, {1'b1, 5'd5, 1'b0});
    chk(ent_vector[47:40] == 8'h42 && ent_dlv[17:15] == 3'd5 && ent_pol[5] && ent_level[5] && !ent_mask[5],
        "R11 pin5 fields", 64'(ent_vector[47:40]), 64'h42);
    rd_chk(12'h010, 32'h0000_A542, "R8 low write clears rirr");
    bus_write(12'h000, 32'h1B);
    bus_write(12'h010, 32'h9C00_0000);
    rd_chk(12'h010, 32'h9C00_0000, "R6 high half");
    chk(ent_dest[47:40] == 8'h9C, "R11 dest", 64'(ent_dest[47:40]), 64'h9C);
    // R9 set from pin side
    @(negedge clk); rirr_set[5] = 1'b1;
    @(negedge clk); rirr_set[5] = 1'b0;
    chk(ent_rirr[5], "R9 rirr set by pin", 64'(ent_rirr[5]), 64'h1);
    bus_write(12'h010, 32'h3300_0000);
    chk(ent_rirr[5], "R8 high write keeps rirr", 64'(ent_rirr[5]), 64'h1);
    bus_write(12'h000, 32'h1A);
    rd_chk(12'h010, 32'h0000_E542, "R9 rirr readback");
    bus_write(12'h010, 32'h0001_E542);
    chk(mchg_valid && mchg_mask, "R10 mask strobe", 64'(mchg_valid), 64'h1);
    rd_chk(12'h010, 32'h0001_A542, "R8 low write forces rirr 0");
    bus_write(12'h010, 32'h0001_E542);
    chk(!mchg_valid, "R10 no strobe when mask same", 64'(mchg_valid), 64'h0);
    // R9 set in same cycle as low write
    @(negedge clk); bus_addr = 12'h010; bus_wdata = 32'h0001_0042; bus_wr = 1'b1; rirr_set[5] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; rirr_set[5] = 1'b0;
    chk(ent_rirr[5], "R9 set wins over low write", 64'(ent_rirr[5]), 64'h1);
    // R2 address aliasing and other offsets
    rd_chk(12'hF10, 32'h0001_4042, "R2 upper bits ignored window");
    bus_write(12'hA00, 32'h3E);
    rd_chk(12'h700, 32'h3E, "R2 upper bits ignored select");
    rd_chk(12'h020, 32'h0, "R2 other offset reads 0");
    bus_write(12'h004, 32'h55);
    rd_chk(12'h000, 32'h3E, "R2 other offset write ignored");
    // R6 last pin, R7 beyond
    bus_write(12'h010, 32'h0000_0077);
    rd_chk(12'h010, 32'h0000_0077, "R6 last pin low");
    bus_write(12'h000, 32'h3F);
    bus_write(12'h010, 32'hFFFF_FFFF);
    rd_chk(12'h010, 32'hFFFF_FFFF, "R6 last pin high");
    bus_write(12'h000, 32'h3C);
    rd_chk(12'h010, 32'h0001_0000, "R6 neighbour untouched");
    bus_write(12'h000, 32'h40);
    bus_write(12'h010, 32'h1234_5678);
    rd_chk(12'h010, 32'h0, "R7 beyond table reads 0");
    bus_write(12'h000, 32'h41);
    bus_write(12'h010, 32'h1234_5678);
    rd_chk(12'h010, 32'h0, "R7 beyond table high");
    bus_write(12'h000, 32'h3E);
    rd_chk(12'h010, 32'h0000_0077, "R7 table unchanged");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule